// File: doc/BRIEF.md
# Debug Comms Mailbox

This block is a one-word mailbox in each direction between a processor core and an external debugger. The debugger reaches it through a small register port: it reads and writes a data location and a control location, each access qualified by a one-cycle read or write strobe. The core sees the same two words through a plain receive port (valid, data, take) and a plain send port (valid, data, ready).

A word the debugger writes waits in the inbound register until the core takes it. A word the core sends waits in the outbound register until the debugger reads the data location. The pending state of each word is shown as a flag in the control word, so the debugger can poll before it moves data. Reading the data location is destructive because it empties the outbound register. A debugger that only wants the flags reads the control location, and that read has no side effect. A sticky overflow output reports that the debugger overwrote an inbound word the core had not yet taken.

Top module: `dcc_mailbox`

## Requirements
- R1: After reset both flags are clear, the overflow output is 0, core_rx_valid is 0 and core_tx_ready is 1.
- R2: A read of the control address (4) returns the inbound flag in bit 0 and the outbound flag in bit 1. Bits 31:28 hold the VERSION parameter (1 to 7) and bits 27:2 read as 0.
- R3: A debugger write to the data address (5) loads the inbound word and sets the inbound flag. From the next cycle core_rx_valid is 1 and core_rx_data shows the word.
- R4: A core take while the inbound flag is set clears it. A take while the flag is clear changes nothing.
- R5: A core send while core_tx_ready is 1 loads the outbound word and sets the outbound flag. A later debugger read of address 5 returns that word.
- R6: A debugger read of address 5 clears the outbound flag. A read of address 4 leaves both flags unchanged.
- R7: While the outbound flag is set, core_tx_ready is 0 and a core send is refused: the stored outbound word does not change.
- R8: A debugger write to address 5 while the inbound flag is set, with no take in the same cycle, replaces the word and sets the overflow output. The overflow output stays 1 until reset.
- R9: A debugger write to address 5 in the same cycle as a core take leaves the inbound flag set with the new word, and does not set overflow.
- R10: Writes to any address other than 5 change no state. Reads of addresses other than 4 and 5 return 0, and a read strobe at such an address does not clear the outbound flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_addr | input | 5 | Debugger register address |
| dbg_rd | input | 1 | Debugger read strobe |
| dbg_wr | input | 1 | Debugger write strobe |
| dbg_wdata | input | 32 | Debugger write data |
| dbg_rdata | output | 32 | Debugger read data (combinational from dbg_addr) |
| core_rx_valid | output | 1 | An inbound word is pending |
| core_rx_data | output | 32 | Inbound word |
| core_rx_take | input | 1 | Core consumes the inbound word |
| core_tx_valid | input | 1 | Core offers an outbound word |
| core_tx_data | input | 32 | Outbound word |
| core_tx_ready | output | 1 | Outbound register is empty |
| ovf_flag | output | 1 | Sticky inbound overwrite indication |

## Verification
The assertions assume that the debugger raises at most one of its two strobes in any cycle. They also assume that dbg_addr is stable while a strobe is high, since rdata is sampled in the strobe cycle. The bench drives every strobe as a single-cycle pulse from a task that sets address, data and strobe together on the falling edge, so these conditions always hold. The one deliberate collision is a debugger data write together with a core take. It is applied only in the R9 case, and the properties for R3, R4 and R8 are written with that collision excluded or covered.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
   // Bit positions inside the control word; the debugger decodes these.
   localparam int unsigned RX_FLAG_BIT = 0;
   localparam int unsigned TX_FLAG_BIT = 1;

   function automatic logic [31:0] ctrl_word(input logic [3:0] ver,
                                             input logic rx_full,
                                             input logic tx_full);
      logic [31:0] w;
      w = '0;
      w[31:28]       = ver;
      w[RX_FLAG_BIT] = rx_full;
      w[TX_FLAG_BIT] = tx_full;
      return w;
   endfunction
endpackage

// File: rtl/dcc_slot.sv
// One-word holding register with a full flag. A set has priority over a clear.
module dcc_slot #(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_i,
   input  logic [WIDTH-1:0] set_data_i,
   input  logic             clr_i,
   output logic             full_o,
   output logic [WIDTH-1:0] data_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full_o <= 1'b0;
         data_o <= '0;
      end else begin
         if (set_i) begin
            full_o <= 1'b1;
            data_o <= set_data_i;
         end else if (clr_i) begin
            full_o <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/dcc_host_port.sv
// Debugger-side address decode and read mux.
module dcc_host_port
   import dcc_pkg::*;
#(
   parameter int unsigned ADDR_W    = 5,
   parameter int unsigned CTRL_ADDR = 4,
   parameter int unsigned DATA_ADDR = 5,
   parameter int unsigned VERSION   = 1
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              rd_i,
   input  logic              wr_i,
   input  logic              rx_full_i,
   input  logic              tx_full_i,
   input  logic [31:0]       tx_data_i,
   output logic [31:0]       rdata_o,
   output logic              rx_load_o,
   output logic              tx_pop_o
);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_ADDR);
   localparam logic [3:0]        VER    = 4'(VERSION);

   logic hit_ctrl, hit_data;

   always_comb begin
      hit_ctrl = (addr_i == CTRL_A);
      hit_data = (addr_i == DATA_A);
      rx_load_o = wr_i && hit_data;
      tx_pop_o  = rd_i && hit_data && tx_full_i;
      if (hit_ctrl)      rdata_o = ctrl_word(VER, rx_full_i, tx_full_i);
      else if (hit_data) rdata_o = tx_data_i;
      else               rdata_o = '0;
   end
endmodule

// File: rtl/dcc_mailbox.sv
module dcc_mailbox #(
   parameter int unsigned ADDR_W    = 5,
   parameter int unsigned CTRL_ADDR = 4,
   parameter int unsigned DATA_ADDR = 5,
   parameter int unsigned VERSION   = 1,
   parameter bit          OVF_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] dbg_addr,
   input  logic              dbg_rd,
   input  logic              dbg_wr,
   input  logic [31:0]       dbg_wdata,
   output logic [31:0]       dbg_rdata,
   output logic              core_rx_valid,
   output logic [31:0]       core_rx_data,
   input  logic              core_rx_take,
   input  logic              core_tx_valid,
   input  logic [31:0]       core_tx_data,
   output logic              core_tx_ready,
   output logic              ovf_flag
);
   localparam int unsigned ADDR_SPAN = 1 << ADDR_W;

   if (VERSION < 1 || VERSION > 7) begin : g_bad_version
      $error("dcc_mailbox: VERSION must lie in 1..7");
   end
   if (CTRL_ADDR == DATA_ADDR) begin : g_bad_map
      $error("dcc_mailbox: control and data addresses must differ");
   end
   if (CTRL_ADDR >= ADDR_SPAN || DATA_ADDR >= ADDR_SPAN) begin : g_bad_addr
      $error("dcc_mailbox: address does not fit ADDR_W");
   end

   logic rx_load, tx_pop, rx_full, tx_full, rx_take_eff, tx_push;
   logic [31:0] tx_word;

   dcc_host_port #(
      .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR),
      .DATA_ADDR(DATA_ADDR), .VERSION(VERSION)
   ) u_port (
      .addr_i(dbg_addr), .rd_i(dbg_rd), .wr_i(dbg_wr),
      .rx_full_i(rx_full), .tx_full_i(tx_full), .tx_data_i(tx_word),
      .rdata_o(dbg_rdata), .rx_load_o(rx_load), .tx_pop_o(tx_pop)
   );

   assign rx_take_eff = core_rx_take && rx_full;
   assign tx_push     = core_tx_valid && !tx_full;

   dcc_slot #(.WIDTH(32)) u_rx_slot (
      .clk(clk), .rst_n(rst_n),
      .set_i(rx_load), .set_data_i(dbg_wdata), .clr_i(rx_take_eff),
      .full_o(rx_full), .data_o(core_rx_data)
   );

   dcc_slot #(.WIDTH(32)) u_tx_slot (
      .clk(clk), .rst_n(rst_n),
      .set_i(tx_push), .set_data_i(core_tx_data), .clr_i(tx_pop),
      .full_o(tx_full), .data_o(tx_word)
   );

   assign core_rx_valid = rx_full;
   assign core_tx_ready = !tx_full;

   if (OVF_EN) begin : g_ovf
      logic ovf_q;
      always_ff @(posedge clk) begin
         if (!rst_n) ovf_q <= 1'b0;
         else if (rx_load && rx_full && !core_rx_take) ovf_q <= 1'b1;
      end
      assign ovf_flag = ovf_q;
   end else begin : g_no_ovf
      assign ovf_flag = 1'b0;
   end
endmodule

// File: rtl/dcc_mailbox_checker.sv
module dcc_mailbox_checker #(
   parameter int unsigned ADDR_W    = 5,
   parameter int unsigned CTRL_ADDR = 4,
   parameter int unsigned DATA_ADDR = 5,
   parameter int unsigned VERSION   = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] dbg_addr,
   input logic              dbg_rd,
   input logic              dbg_wr,
   input logic [31:0]       dbg_wdata,
   input logic [31:0]       dbg_rdata,
   input logic              core_rx_valid,
   input logic [31:0]       core_rx_data,
   input logic              core_rx_take,
   input logic              core_tx_valid,
   input logic              core_tx_ready,
   input logic              ovf_flag
);
   localparam logic [ADDR_W-1:0] CA = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] DA = ADDR_W'(DATA_ADDR);

   assert_ctrl_fields_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_addr == CA) |-> (dbg_rdata[31:28] == 4'(VERSION) && dbg_rdata[27:2] == '0
                            && dbg_rdata[1] == !core_tx_ready && dbg_rdata[0] == core_rx_valid));

   assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_wr && dbg_addr == DA) |=> (core_rx_valid && core_rx_data == $past(dbg_wdata)));

   assert_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (core_rx_take && !(dbg_wr && dbg_addr == DA)) |=> !core_rx_valid);

   assert_ctrl_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_rd && dbg_addr == CA && !core_tx_valid) |=> $stable(core_tx_ready));

   assert_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!core_tx_ready && !(dbg_rd && dbg_addr == DA)) |=> !core_tx_ready);

   assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_flag |=> ovf_flag);

   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovf_flag && !(dbg_wr && dbg_addr == DA && core_rx_valid && !core_rx_take)) |=> !ovf_flag);

   assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(dbg_rd && dbg_wr));
endmodule

bind dcc_mailbox dcc_mailbox_checker #(
   .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .DATA_ADDR(DATA_ADDR), .VERSION(VERSION)
) u_chk (
   .clk(clk), .rst_n(rst_n), .dbg_addr(dbg_addr), .dbg_rd(dbg_rd), .dbg_wr(dbg_wr),
   .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata), .core_rx_valid(core_rx_valid),
   .core_rx_data(core_rx_data), .core_rx_take(core_rx_take),
   .core_tx_valid(core_tx_valid), .core_tx_ready(core_tx_ready), .ovf_flag(ovf_flag)
);

// File: tb/dcc_mailbox_bench.sv
module dcc_mailbox_bench;
   localparam int unsigned VER = 5;
   localparam logic [31:0] VBASE = 32'(VER) << 28;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [4:0] dbg_addr = '0;
   logic dbg_rd = 1'b0, dbg_wr = 1'b0;
   logic [31:0] dbg_wdata = '0, dbg_rdata;
   logic core_rx_valid, core_rx_take = 1'b0;
   logic [31:0] core_rx_data;
   logic core_tx_valid = 1'b0, core_tx_ready, ovf_flag;
   logic [31:0] core_tx_data = '0;

   int n_run = 0, n_fail = 0;
   bit done = 0;

   always #4 clk = ~clk;

   dcc_mailbox #(.VERSION(VER)) u_dcc_mailbox (
      .clk(clk), .rst_n(rst_n), .dbg_addr(dbg_addr), .dbg_rd(dbg_rd), .dbg_wr(dbg_wr),
      .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata), .core_rx_valid(core_rx_valid),
      .core_rx_data(core_rx_data), .core_rx_take(core_rx_take),
      .core_tx_valid(core_tx_valid), .core_tx_data(core_tx_data),
      .core_tx_ready(core_tx_ready), .ovf_flag(ovf_flag)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic dbg_write(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk); dbg_addr = a; dbg_wdata = d; dbg_wr = 1'b1;
      @(negedge clk); dbg_wr = 1'b0;
   endtask

   task automatic dbg_read(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk); dbg_addr = a; dbg_rd = 1'b1; #1 d = dbg_rdata;
      @(negedge clk); dbg_rd = 1'b0;
   endtask

   task automatic peek(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk); dbg_addr = a; #1 d = dbg_rdata;
   endtask

   task automatic core_take();
      @(negedge clk); core_rx_take = 1'b1;
      @(negedge clk); core_rx_take = 1'b0;
   endtask

   task automatic core_send(input logic [31:0] d);
      @(negedge clk); core_tx_data = d; core_tx_valid = 1'b1;
      @(negedge clk); core_tx_valid = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(8 * 150000);
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] v, p, q;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 / R2 reset state
      peek(5'd4, v); check("R1 ctrl after reset", v, VBASE);
      check("R1 rx_valid", 32'(core_rx_valid), 0);
      check("R1 tx_ready", 32'(core_tx_ready), 1);
      check("R1 ovf", 32'(ovf_flag), 0);

      for (int k = 0; k < 16; k++) begin
         p = (32'(k) * 32'h1F3D5B79) ^ 32'hA5A5_0000;
         q = ~p + 32'(k);
         // R3 inbound
         dbg_write(5'd5, p);
         peek(5'd4, v); check("R2 R3 ctrl inbound pending", v, VBASE | 32'd1);
         check("R3 rx_data", core_rx_data, p);
         check("R3 rx_valid", 32'(core_rx_valid), 1);
         core_take();
         check("R4 rx_valid after take", 32'(core_rx_valid), 0);
         peek(5'd4, v); check("R4 ctrl after take", v, VBASE);
         // R5 outbound
         core_send(q);
         check("R5 tx_ready after send", 32'(core_tx_ready), 0);
         dbg_read(5'd4, v); check("R2 R5 ctrl outbound pending", v, VBASE | 32'd2);
         dbg_read(5'd4, v); check("R6 ctrl read keeps flag", v, VBASE | 32'd2);
         dbg_read(5'd5, v); check("R5 outbound word", v, q);
         peek(5'd4, v); check("R6 data read clears flag", v, VBASE);
      end

      // R7 refused send
      core_send(32'h1111_2222);
      core_send(32'h3333_4444);
      check("R7 tx_ready low", 32'(core_tx_ready), 0);
      dbg_read(5'd5, v); check("R7 word kept", v, 32'h1111_2222);
      check("R6 tx_ready after pop", 32'(core_tx_ready), 1);

      // R4 take when empty
      core_take();
      peek(5'd4, v); check("R4 empty take", v, VBASE);
      check("R4 ovf after empty take", 32'(ovf_flag), 0);

      // R9 write with simultaneous take
      dbg_write(5'd5, 32'hCAFE_0001);
      @(negedge clk); dbg_addr = 5'd5; dbg_wdata = 32'hCAFE_0002; dbg_wr = 1'b1; core_rx_take = 1'b1;
      @(negedge clk); dbg_wr = 1'b0; core_rx_take = 1'b0;
      check("R9 rx_valid", 32'(core_rx_valid), 1);
      check("R9 rx_data", core_rx_data, 32'hCAFE_0002);
      check("R9 ovf", 32'(ovf_flag), 0);
      core_take();

      // R10 other addresses
      core_send(32'h5A5A_A5A5);
      for (int a = 0; a < 32; a++) begin
         if (a != 5) begin
            dbg_write(5'(a), 32'hFFFF_FFFF);
            check("R10 write elsewhere rx_valid", 32'(core_rx_valid), 0);
            if (a != 4) begin
               dbg_read(5'(a), v); check("R10 read elsewhere zero", v, 0);
            end
         end
      end
      peek(5'd4, v); check("R10 flags untouched", v, VBASE | 32'd2);
      check("R10 ovf untouched", 32'(ovf_flag), 0);
      dbg_read(5'd5, v); check("R10 outbound word intact", v, 32'h5A5A_A5A5);

      // R8 overwrite
      dbg_write(5'd5, 32'hBEEF_0001);
      dbg_write(5'd5, 32'hBEEF_0002);
      check("R8 overwrite data", core_rx_data, 32'hBEEF_0002);
      check("R8 ovf set", 32'(ovf_flag), 1);
      core_take();
      core_send(32'h0);
      dbg_read(5'd5, v);
      check("R8 ovf sticky", 32'(ovf_flag), 1);

      // R1 reset again
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      check("R1 ovf cleared by reset", 32'(ovf_flag), 0);
      peek(5'd4, v); check("R1 ctrl after second reset", v, VBASE);

      finish_run();
   end
endmodule